// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block turns a fast functional clock into the SCL clock waveform of an I2C master. A programmable prescaler first divides the functional clock into an internal tick. The low and high phases of SCL are then timed in ticks. The low phase lasts the programmed low count plus seven ticks. The high phase lasts the programmed high count plus five ticks. The resulting bit rate is fclk / ((P + 1) * (L + 7 + H + 5)). For example, a 48 MHz clock with P = 1 and L/H = 23/25 gives 400 kHz. A 96 MHz clock with P = 23 and L/H = 13/15 gives 100 kHz.

A byte engine starts the clock with `run` and ends it by dropping `run`. It uses three one-cycle strobes to stay in step with the clock: one when SCL is pulled low, one when SCL is first seen high, and one at the middle of the low phase, where SDA may change. The high phase is counted only once the sampled line is really high, so a slave holding SCL low stretches the clock. The three timing values are captured only while the generator is idle. The sum of the captured counts is offered as a readback value.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever idle, `scl_pull_low` is 0 and `fall_stb`, `rise_stb` and `mid_low_stb` are 0.
- R2: Each low phase (`scl_pull_low` = 1) lasts exactly (L + 7) * (P + 1) clock cycles, where P, L and H are the captured `psc_val`, `low_val` and `high_val`.
- R3: With the line free, each high phase lasts exactly (H + 5) * (P + 1) clock cycles.
- R4: While SCL is released but `scl_in` is still 0, `rise_stb` stays 0 and the high count does not advance. The (H + 5) * (P + 1) cycles start in the first cycle in which `scl_in` is 1.
- R5: `fall_stb` is 1 only in the first cycle of each low phase. `rise_stb` is 1 only in the first cycle of a high phase in which `scl_in` is 1. At most one strobe is active in any cycle.
- R6: `mid_low_stb` is 1 exactly once per low phase, in low-phase cycle floor((L + 7) / 2) * (P + 1), counting the first low cycle as 0.
- R7: Values on `psc_val`, `low_val` and `high_val` are captured only while idle. A change made while SCL is running has no effect until the next start from idle.
- R8: If `run` is 0 at the end of a high phase, the generator goes idle with SCL released and no further `fall_stb`. Otherwise the next low phase follows at once.
- R9: When `enable` is 0, the generator is forced idle: from the next cycle on, `scl_pull_low` and `fall_stb` are 0.
- R10: `period_ticks` equals L + H + 12 for the captured values. While idle, it follows the inputs one cycle later.
- R11: A new clock run starts from idle only when both `enable` and `run` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 forces idle |
| run | input | 1 | Run request from the byte engine |
| psc_val | input | PW | Prescaler value P (tick = P + 1 clocks) |
| low_val | input | CW | Low count L (low phase = L + 7 ticks) |
| high_val | input | CW | High count H (high phase = H + 5 ticks) |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle SCL is seen high in a high phase |
| mid_low_stb | output | 1 | Middle of the low phase, where SDA may change |
| period_ticks | output | CW+2 | Captured L + H + 12 |

## Verification
The bench builds the block with its default 8-bit prescaler and 8-bit counts. These widths reach both extremes within a short run: P = 0, where a tick falls on every cycle, and L = H = 255, where the phase counter reaches its largest compare value of 261. The bench also runs two realistic rate settings, one at 48 MHz and one at 96 MHz. Mid-run register changes, clock stretching, a late stop and a forced disable are all observed only through the phase lengths and strobes on the ports.

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen #(
  parameter int PW       = 8,
  parameter int CW       = 8,
  parameter int LOW_ADD  = 7,
  parameter int HIGH_ADD = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          run,
  input  logic [PW-1:0] psc_val,
  input  logic [CW-1:0] low_val,
  input  logic [CW-1:0] high_val,
  input  logic          scl_in,
  output logic          scl_pull_low,
  output logic          fall_stb,
  output logic          rise_stb,
  output logic          mid_low_stb,
  output logic [CW+1:0] period_ticks
);
  localparam int TW = CW + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;
  st_t           state;
  logic [PW-1:0] psc_q, pcnt;
  logic [CW-1:0] low_q, high_q;
  logic [TW-1:0] tcnt;
  logic          seen_high;

  wire           idle      = (state == S_IDLE);
  wire           start     = idle & enable & run;
  wire           go        = (state == S_LOW) | ((state == S_HIGH) & (seen_high | scl_in));
  wire           tick      = go & (pcnt == psc_q);
  wire [TW-1:0]  low_last  = TW'(low_q) + TW'(LOW_ADD - 1);
  wire [TW-1:0]  high_last = TW'(high_q) + TW'(HIGH_ADD - 1);
  wire [TW-1:0]  low_half  = (TW'(low_q) + TW'(LOW_ADD)) >> 1;
  wire           low_end   = tick & (state == S_LOW) & (tcnt == low_last);
  wire           high_end  = tick & (state == S_HIGH) & (tcnt == high_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      psc_q       <= '0;
      low_q       <= '0;
      high_q      <= '0;
      pcnt        <= '0;
      tcnt        <= '0;
      seen_high   <= 1'b0;
      fall_stb    <= 1'b0;
      mid_low_stb <= 1'b0;
    end else begin
      fall_stb    <= 1'b0;
      mid_low_stb <= 1'b0;
      if (idle) begin
        psc_q  <= psc_val;
        low_q  <= low_val;
        high_q <= high_val;
      end
      if (!enable) begin
        state     <= S_IDLE;
        pcnt      <= '0;
        tcnt      <= '0;
        seen_high <= 1'b0;
      end else if (start) begin
        state    <= S_LOW;
        pcnt     <= '0;
        tcnt     <= '0;
        fall_stb <= 1'b1;
      end else if (go) begin
        if (state == S_HIGH) seen_high <= 1'b1;
        if (!tick) begin
          pcnt <= pcnt + PW'(1);
        end else begin
          pcnt <= '0;
          if (low_end) begin
            state     <= S_HIGH;
            tcnt      <= '0;
            seen_high <= 1'b0;
          end else if (high_end) begin
            tcnt      <= '0;
            seen_high <= 1'b0;
            if (run) begin
              state    <= S_LOW;
              fall_stb <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            tcnt <= tcnt + TW'(1);
            if ((state == S_LOW) && ((tcnt + TW'(1)) == low_half)) mid_low_stb <= 1'b1;
          end
        end
      end
    end
  end

  assign scl_pull_low = (state == S_LOW);
  assign rise_stb     = (state == S_HIGH) & scl_in & ~seen_high;
  assign period_ticks = (CW+2)'(low_q) + (CW+2)'(high_q) + (CW+2)'(LOW_ADD + HIGH_ADD);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb, mid_low_stb}));

  assert_fall_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (scl_pull_low && !$past(scl_pull_low)));

  assert_rise_needs_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_in && !scl_pull_low));

  assert_stretch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_HIGH) && !seen_high && !scl_in && enable) |=>
      ((state == S_HIGH) && (pcnt == '0) && (tcnt == '0)));

  assert_mid_inside_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mid_low_stb |-> (scl_pull_low && $past(scl_pull_low)));

  assert_low_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> (tcnt <= low_last));

  assert_frozen_while_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> ($stable(psc_q) && $stable(low_q) && $stable(high_q)));

  assert_disable_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !fall_stb));
endmodule

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n, enable, run, stretch;
  logic [7:0] psc_val, low_val, high_val;
  logic       scl_in, scl_pull_low, fall_stb, rise_stb, mid_low_stb;
  logic [9:0] period_ticks;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign scl_in = ~scl_pull_low & ~stretch;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
    .psc_val(psc_val), .low_val(low_val), .high_val(high_val),
    .scl_in(scl_in), .scl_pull_low(scl_pull_low), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .mid_low_stb(mid_low_stb), .period_ticks(period_ticks));

  // {psc, low, high}
  localparam logic [23:0] VEC [6] = '{
    {8'd0,  8'd0,   8'd0},
    {8'd1,  8'd5,   8'd7},
    {8'd3,  8'd2,   8'd9},
    {8'd1,  8'd111, 8'd117},
    {8'd23, 8'd13,  8'd15},
    {8'd2,  8'd255, 8'd255}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_fall(output bit got);
    got = 0;
    for (int i = 0; i < 4000 && !got; i++) begin
      step();
      if (fall_stb) got = 1;
    end
  endtask

  task automatic measure_low(output int n, output int mid, output int midc);
    n = 0; mid = -1; midc = 0;
    while (scl_pull_low && n < 5000) begin
      if (mid_low_stb) begin mid = n; midc++; end
      n++;
      step();
    end
  endtask

  task automatic measure_high(output int h);
    h = 0;
    while (!scl_pull_low && h < 5000) begin
      h++;
      step();
    end
  endtask

  task automatic wait_release();
    for (int i = 0; i < 5000 && scl_pull_low; i++) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit got;
    int n, mid, midc, h, p, l, hi, quiet;
    rst_n = 0; enable = 0; run = 0; stretch = 0;
    psc_val = 8'd0; low_val = 8'd0; high_val = 8'd0;
    repeat (4) step();
    chk(!scl_pull_low && !fall_stb && !rise_stb && !mid_low_stb, "R1 reset outputs",
        {scl_pull_low, fall_stb, rise_stb, mid_low_stb}, 0);
    rst_n = 1; enable = 1;
    repeat (3) step();
    chk(!scl_pull_low && !fall_stb && !rise_stb && !mid_low_stb, "R1 idle outputs",
        {scl_pull_low, fall_stb, rise_stb, mid_low_stb}, 0);

    // R11: no start without both enable and run
    quiet = 1;
    for (int i = 0; i < 20; i++) begin step(); if (scl_pull_low || fall_stb) quiet = 0; end
    chk(quiet == 1, "R11 run low keeps idle", quiet, 1);
    enable = 0; run = 1;
    quiet = 1;
    for (int i = 0; i < 20; i++) begin step(); if (scl_pull_low || fall_stb) quiet = 0; end
    chk(quiet == 1, "R11 enable low keeps idle", quiet, 1);
    run = 0; enable = 1;
    step();

    // vector table walk: R2 R3 R5 R6 R8 R10
    foreach (VEC[v]) begin
      p = VEC[v][23:16]; l = VEC[v][15:8]; hi = VEC[v][7:0];
      psc_val = 8'(p); low_val = 8'(l); high_val = 8'(hi);
      repeat (3) step();
      chk(period_ticks == 10'(l + hi + 12), "R10 period readback", period_ticks, l + hi + 12);
      run = 1;
      wait_fall(got);
      chk(got, "R5 fall strobe at start", got, 1);
      measure_low(n, mid, midc);
      chk(n == (l + 7) * (p + 1), "R2 low length", n, (l + 7) * (p + 1));
      chk(mid == ((l + 7) / 2) * (p + 1), "R6 mid-low position", mid, ((l + 7) / 2) * (p + 1));
      chk(midc == 1, "R6 mid-low once", midc, 1);
      chk(rise_stb == 1'b1, "R5 rise strobe first high cycle", rise_stb, 1);
      measure_high(h);
      chk(h == (hi + 5) * (p + 1), "R3 high length", h, (hi + 5) * (p + 1));
      chk(fall_stb == 1'b1, "R8 next low follows with run", fall_stb, 1);
      run = 0;
      wait_release();
      quiet = 1;
      for (int i = 0; i < (hi + 5) * (p + 1) + 20; i++) begin
        step();
        if (scl_pull_low || fall_stb) quiet = 0;
      end
      chk(quiet == 1, "R8 stop after high phase", quiet, 1);
    end

    // R4 clock stretching
    psc_val = 8'd1; low_val = 8'd5; high_val = 8'd7;
    repeat (2) step();
    stretch = 1; run = 1;
    wait_fall(got);
    measure_low(n, mid, midc);
    quiet = 1;
    for (int i = 0; i < 10; i++) begin
      if (rise_stb || scl_pull_low) quiet = 0;
      step();
    end
    chk(quiet == 1, "R4 no rise while held low", quiet, 1);
    stretch = 0;
    #1;
    chk(rise_stb == 1'b1, "R4 rise when line seen high", rise_stb, 1);
    h = 10;
    while (!scl_pull_low && h < 5000) begin h++; step(); end
    chk(h == 34, "R4 stretched high length", h, 34);
    run = 0;
    wait_release();
    repeat (40) step();

    // R7 mid-run register change ignored
    run = 1;
    wait_fall(got);
    psc_val = 8'd0; low_val = 8'd0; high_val = 8'd0;
    measure_low(n, mid, midc);
    chk(n == 24, "R7 low unchanged mid-run", n, 24);
    measure_high(h);
    chk(h == 24, "R7 high unchanged mid-run", h, 24);
    chk(period_ticks == 10'd24, "R7 readback frozen", period_ticks, 24);
    run = 0;
    wait_release();
    repeat (40) step();
    chk(period_ticks == 10'd12, "R10 readback after idle", period_ticks, 12);
    run = 1;
    wait_fall(got);
    measure_low(n, mid, midc);
    chk(n == 7, "R7 new values at next start", n, 7);
    run = 0;
    repeat (30) step();

    // R9 disable forces idle
    psc_val = 8'd3; low_val = 8'd20; high_val = 8'd20;
    repeat (2) step();
    run = 1;
    wait_fall(got);
    repeat (5) step();
    enable = 0;
    step();
    chk(scl_pull_low == 1'b0, "R9 release after disable", scl_pull_low, 0);
    quiet = 1;
    for (int i = 0; i < 20; i++) begin step(); if (scl_pull_low || fall_stb) quiet = 0; end
    chk(quiet == 1, "R9 stays idle while disabled", quiet, 1);
    chk(!rise_stb && !mid_low_stb, "R1 strobes quiet when idle", {rise_stb, mid_low_stb}, 0);
    enable = 1; run = 0;
    repeat (3) step();
    finish_run();
  end
endmodule